// File: doc/BRIEF.md
# ALU Flag Generator with Status Word

This block performs 8-bit or 16-bit addition, subtraction and bitwise logic on two operands. It registers the result and derives the arithmetic status flags from it: carry/borrow, nibble carry for decimal adjust, overflow, sign, zero and parity. The same 16-bit status word holds three program-controlled flags (string direction, maskable interrupt enable and single-step trap). Arithmetic never alters those three. They change only through a dedicated write port or through a full-word restore port.

A datapath asserts `exec` with an operation code and a size select. On the next clock edge the result register and the status bits of the word update together. A context restore uses `load_en` to overwrite every writable bit in one cycle. Bits 15..12 of the word always read 1 and the unused bits always read 0.

Top module: `flag_unit`

## Requirements
- R1: Synchronous reset sets the status word to 0xF000 and the result register to 0.
- R2: With `exec` high, op 0 registers a+b+cin and op 1 registers a-b-cin. The size comes from `wide` (1 = 16 bits, 0 = 8 bits). A byte result is zero-extended to 16 bits, and the result appears on the edge that samples `exec`.
- R3: Bit 0 (carry) is set when an add carries out of the top bit of the selected size, or when a subtract borrows into it.
- R4: Bit 4 (auxiliary) is set when an add carries out of bit 3, or when a subtract borrows into bit 3. This is measured on the low byte for both sizes.
- R5: Bit 11 (overflow) is set when the signed result of an add or subtract does not fit in the selected size.
- R6: Bit 7 (sign) equals the top bit of the result at the selected size. Bit 6 (zero) is set when the result at that size is all zeros.
- R7: Bit 2 (parity) is set when the low 8 bits of the result hold an even number of ones, for both sizes.
- R8: Ops 2, 3 and 4 (AND, OR, XOR) clear carry, overflow and auxiliary, and update sign, zero and parity from the result.
- R9: With `ctl_we` high, bits 8 (trap), 9 (interrupt enable) and 10 (direction) take `ctl_tf`, `ctl_ie` and `ctl_dir`. Operations never change these bits.
- R10: With `exec` low, or with an op code of 5 to 7, the result and the status bits keep their values.
- R11: With `load_en` high, the word becomes (`load_word` AND 0x0FD5) OR 0xF000. This takes priority over any status or control update in the same cycle, while the result register still follows R2.
- R12: Bits 15..12 always read 1 and bits 1, 3 and 5 always read 0. Each flag output equals its bit in the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry-in (add) or borrow-in (subtract) |
| op | input | 3 | 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5-7 no operation |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| exec | input | 1 | Perform the operation this cycle |
| ctl_we | input | 1 | Write the three control flags |
| ctl_dir | input | 1 | Direction value (1 = decrement) |
| ctl_ie | input | 1 | Interrupt-enable value |
| ctl_tf | input | 1 | Trap value |
| load_en | input | 1 | Restore the whole status word |
| load_word | input | 16 | Word to restore |
| result | output | 16 | Registered result |
| psw | output | 16 | Status word |
| cf | output | 1 | Carry flag |
| pf | output | 1 | Parity flag |
| af | output | 1 | Auxiliary flag |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| of | output | 1 | Overflow flag |
| df | output | 1 | Direction flag |
| ief | output | 1 | Interrupt-enable flag |
| tf | output | 1 | Trap flag |

## Verification
Byte-mode adds at 0x0F+1, 0x7F+1 and 0xFF+1 separate the nibble carry, signed overflow and unsigned carry, which a single-flag bug would merge. Subtracts across 0x00, 0x10 and 0x8000, with and without borrow-in, check that carry is inverted into a borrow and that overflow uses the effective operand. Byte-mode logic operands with non-zero upper bytes, and a word result whose low byte is zero, separate zero-extension and low-byte parity from full-width evaluation. Control writes interleaved with operations, reserved op codes, idle cycles and restores issued together with `exec` separate the update priorities.

// File: rtl/flag_pkg.sv
`timescale 1ns/1ps
package flag_pkg;
  localparam int PSW_W = 16;
  localparam int CF_B = 0;
  localparam int PF_B = 2;
  localparam int AF_B = 4;
  localparam int ZF_B = 6;
  localparam int SF_B = 7;
  localparam int TF_B = 8;
  localparam int IF_B = 9;
  localparam int DF_B = 10;
  localparam int OF_B = 11;
  localparam logic [PSW_W-1:0] PSW_ONES  = 16'hF000;
  localparam logic [PSW_W-1:0] PSW_WMASK = 16'h0FD5;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } op_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } stat_t;
endpackage

// File: rtl/flag_arith.sv
`timescale 1ns/1ps
module flag_arith #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  input  logic          wide,
  output logic [DW-1:0] res,
  output logic          cf,
  output logic          af,
  output logic          of
);
  localparam int HW = DW / 2;

  logic [DW-1:0] b_eff;
  logic          c_eff;
  logic [DW:0]   sum_w;
  logic [HW:0]   sum_b;
  logic          a_top, b_top, r_top;

  always_comb begin
    b_eff = sub ? ~b : b;
    c_eff = cin ^ sub;
    sum_w = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
    sum_b = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, c_eff};
    if (wide) begin
      res   = sum_w[DW-1:0];
      cf    = sum_w[DW] ^ sub;
      a_top = a[DW-1];
      b_top = b_eff[DW-1];
      r_top = sum_w[DW-1];
    end else begin
      res   = {{(DW-HW){1'b0}}, sum_b[HW-1:0]};
      cf    = sum_b[HW] ^ sub;
      a_top = a[HW-1];
      b_top = b_eff[HW-1];
      r_top = sum_b[HW-1];
    end
    af = a[4] ^ b[4] ^ sum_b[4];
    of = (a_top == b_top) && (r_top != a_top);
  end
endmodule

// File: rtl/flag_logic.sv
`timescale 1ns/1ps
module flag_logic #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [2:0]    op,
  input  logic          wide,
  output logic [DW-1:0] res
);
  import flag_pkg::*;
  localparam int HW = DW / 2;

  logic [DW-1:0] raw;
  logic [DW-1:0] keep;

  always_comb begin
    case (op)
      OP_AND:  raw = a & b;
      OP_OR:   raw = a | b;
      default: raw = a ^ b;
    endcase
    keep = wide ? {DW{1'b1}} : {{(DW-HW){1'b0}}, {HW{1'b1}}};
    res  = raw & keep;
  end
endmodule

// File: rtl/flag_zsp.sv
`timescale 1ns/1ps
module flag_zsp #(
  parameter int DW    = 16,
  parameter int PAR_W = 8
) (
  input  logic [DW-1:0] res,
  input  logic          wide,
  output logic          zf,
  output logic          sf,
  output logic          pf
);
  localparam int HW = DW / 2;

  always_comb begin
    zf = wide ? (res == '0) : (res[HW-1:0] == '0);
    sf = wide ? res[DW-1] : res[HW-1];
    pf = ~^res[PAR_W-1:0];
  end
endmodule

// File: rtl/flag_psw.sv
`timescale 1ns/1ps
module flag_psw (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         upd_stat,
  input  flag_pkg::stat_t              stat_in,
  input  logic                         ctl_we,
  input  logic                         ctl_dir,
  input  logic                         ctl_ie,
  input  logic                         ctl_tf,
  input  logic                         load_en,
  input  logic [flag_pkg::PSW_W-1:0]   load_word,
  output logic [flag_pkg::PSW_W-1:0]   psw
);
  import flag_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      psw <= PSW_ONES;
    end else if (load_en) begin
      psw <= (load_word & PSW_WMASK) | PSW_ONES;
    end else begin
      if (upd_stat) begin
        psw[CF_B] <= stat_in.cf;
        psw[PF_B] <= stat_in.pf;
        psw[AF_B] <= stat_in.af;
        psw[ZF_B] <= stat_in.zf;
        psw[SF_B] <= stat_in.sf;
        psw[OF_B] <= stat_in.of;
      end
      if (ctl_we) begin
        psw[TF_B] <= ctl_tf;
        psw[IF_B] <= ctl_ie;
        psw[DF_B] <= ctl_dir;
      end
    end
  end
endmodule

// File: rtl/flag_unit.sv
`timescale 1ns/1ps
module flag_unit #(
  parameter int DW    = 16,
  parameter int PAR_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic [2:0]    op,
  input  logic          wide,
  input  logic          exec,
  input  logic          ctl_we,
  input  logic          ctl_dir,
  input  logic          ctl_ie,
  input  logic          ctl_tf,
  input  logic          load_en,
  input  logic [15:0]   load_word,
  output logic [DW-1:0] result,
  output logic [15:0]   psw,
  output logic          cf,
  output logic          pf,
  output logic          af,
  output logic          zf,
  output logic          sf,
  output logic          of,
  output logic          df,
  output logic          ief,
  output logic          tf
);
  import flag_pkg::*;

  logic          op_ok, is_arith;
  logic [DW-1:0] ar_res, lg_res, nxt_res;
  logic          ar_cf, ar_af, ar_of;
  logic          z_n, s_n, p_n;
  stat_t         stat_n;

  assign op_ok    = (op <= OP_XOR);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);

  flag_arith #(.DW(DW)) u_arith (
    .a(a), .b(b), .cin(cin), .sub(op == OP_SUB), .wide(wide),
    .res(ar_res), .cf(ar_cf), .af(ar_af), .of(ar_of)
  );

  flag_logic #(.DW(DW)) u_logic (
    .a(a), .b(b), .op(op), .wide(wide), .res(lg_res)
  );

  assign nxt_res = is_arith ? ar_res : lg_res;

  flag_zsp #(.DW(DW), .PAR_W(PAR_W)) u_zsp (
    .res(nxt_res), .wide(wide), .zf(z_n), .sf(s_n), .pf(p_n)
  );

  always_comb begin
    stat_n.cf = is_arith & ar_cf;
    stat_n.af = is_arith & ar_af;
    stat_n.of = is_arith & ar_of;
    stat_n.zf = z_n;
    stat_n.sf = s_n;
    stat_n.pf = p_n;
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else if (exec && op_ok) result <= nxt_res;
  end

  flag_psw u_psw (
    .clk(clk), .rst(rst), .upd_stat(exec && op_ok), .stat_in(stat_n),
    .ctl_we(ctl_we), .ctl_dir(ctl_dir), .ctl_ie(ctl_ie), .ctl_tf(ctl_tf),
    .load_en(load_en), .load_word(load_word), .psw(psw)
  );

  assign cf  = psw[CF_B];
  assign pf  = psw[PF_B];
  assign af  = psw[AF_B];
  assign zf  = psw[ZF_B];
  assign sf  = psw[SF_B];
  assign of  = psw[OF_B];
  assign df  = psw[DF_B];
  assign ief = psw[IF_B];
  assign tf  = psw[TF_B];
endmodule

// File: rtl/flag_unit_chk.sv
`timescale 1ns/1ps
module flag_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        exec,
  input logic [2:0]  op,
  input logic        wide,
  input logic        ctl_we,
  input logic        load_en,
  input logic [15:0] result,
  input logic [15:0] psw
);
  logic act;
  assign act = exec && (op <= 3'd4) && !load_en;

  p_reset_word_r1: assert property (@(posedge clk) rst |=> (psw == 16'hF000 && result == 16'h0));

  p_fixed_bits_r12: assert property (@(posedge clk) disable iff (rst)
    (psw[15:12] == 4'hF && !psw[5] && !psw[3] && !psw[1]));

  p_logic_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (act && (op >= 3'd2)) |=> (!psw[0] && !psw[11] && !psw[4]));

  p_ctl_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!ctl_we && !load_en) |=> $stable(psw[10:8]));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!load_en && (!exec || op > 3'd4)) |=> ($stable(result) && $stable({psw[11], psw[7:0]})));

  p_zero_r6: assert property (@(posedge clk) disable iff (rst)
    act |=> (psw[6] == (result == 16'h0)));

  p_sign_r6: assert property (@(posedge clk) disable iff (rst)
    act |=> (psw[7] == ($past(wide) ? result[15] : result[7])));

  p_parity_r7: assert property (@(posedge clk) disable iff (rst)
    act |=> (psw[2] == ~^result[7:0]));
endmodule

bind flag_unit flag_unit_chk u_chk (
  .clk(clk), .rst(rst), .exec(exec), .op(op), .wide(wide), .ctl_we(ctl_we),
  .load_en(load_en), .result(result), .psw(psw)
);

// File: tb/flag_unit_test.sv
`timescale 1ns/1ps
module flag_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a = '0, b = '0, load_word = '0;
  logic        cin = 1'b0, wide = 1'b0, exec = 1'b0;
  logic [2:0]  op = '0;
  logic        ctl_we = 1'b0, ctl_dir = 1'b0, ctl_ie = 1'b0, ctl_tf = 1'b0, load_en = 1'b0;
  logic [15:0] result, psw;
  logic        cf, pf, af, zf, sf, of, df, ief, tf;

  int errors = 0;
  int checks = 0;
  logic [15:0] m_res = 16'h0;
  logic [15:0] m_psw = 16'hF000;
  string       tq[$];
  logic [15:0] rq[$];
  logic [15:0] pq[$];

  always #4 clk = ~clk;

  flag_unit uut (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .op(op), .wide(wide),
    .exec(exec), .ctl_we(ctl_we), .ctl_dir(ctl_dir), .ctl_ie(ctl_ie), .ctl_tf(ctl_tf),
    .load_en(load_en), .load_word(load_word), .result(result), .psw(psw),
    .cf(cf), .pf(pf), .af(af), .zf(zf), .sf(sf), .of(of), .df(df), .ief(ief), .tf(tf)
  );

  task automatic check(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // independent model of an operation, from the requirements
  task automatic model(input logic [15:0] xa, input logic [15:0] xb, input logic ci,
                       input logic [2:0] xop, input logic w,
                       output logic [15:0] r, output logic [15:0] stbits);
    int mask, bits, ua, ub, sa, sb, full, s, rr, ones;
    logic c, h, v;
    mask = w ? 32'hFFFF : 32'hFF;
    bits = w ? 16 : 8;
    ua = int'(xa) & mask;
    ub = int'(xb) & mask;
    sa = (ua >= (1 << (bits-1))) ? ua - (1 << bits) : ua;
    sb = (ub >= (1 << (bits-1))) ? ub - (1 << bits) : ub;
    c = 1'b0; h = 1'b0; v = 1'b0; s = 0;
    case (xop)
      3'd0: begin
        full = ua + ub + int'(ci);
        c = full > mask;
        h = ((ua & 15) + (ub & 15) + int'(ci)) > 15;
        s = sa + sb + int'(ci);
      end
      3'd1: begin
        full = ua - ub - int'(ci);
        c = full < 0;
        h = (ua & 15) < ((ub & 15) + int'(ci));
        s = sa - sb - int'(ci);
      end
      3'd2: full = ua & ub;
      3'd3: full = ua | ub;
      default: full = ua ^ ub;
    endcase
    rr = full & mask;
    if (xop <= 3'd1) v = (s > ((1 << (bits-1)) - 1)) || (s < -(1 << (bits-1)));
    ones = $countones(rr & 255);
    r = rr[15:0];
    stbits = 16'h0;
    stbits[0]  = c;
    stbits[2]  = (ones % 2) == 0;
    stbits[4]  = h;
    stbits[6]  = (rr == 0);
    stbits[7]  = rr[bits-1];
    stbits[11] = v;
  endtask

  task automatic step(input string tag, input logic [15:0] xa, input logic [15:0] xb,
                      input logic ci, input logic [2:0] xop, input logic w, input logic ex,
                      input logic cwe, input logic [2:0] ctl, input logic ld, input logic [15:0] lw);
    logic [15:0] r, st, np;
    @(negedge clk);
    a = xa; b = xb; cin = ci; op = xop; wide = w; exec = ex;
    ctl_we = cwe; ctl_dir = ctl[2]; ctl_ie = ctl[1]; ctl_tf = ctl[0];
    load_en = ld; load_word = lw;
    np = m_psw;
    if (ex && xop <= 3'd4) begin
      model(xa, xb, ci, xop, w, r, st);
      m_res = r;
      np = (np & ~16'h08D5) | st;
    end
    if (cwe) begin
      np[10] = ctl[2]; np[9] = ctl[1]; np[8] = ctl[0];
    end
    if (ld) np = (lw & 16'h0FD5) | 16'hF000;
    m_psw = np;
    @(posedge clk);
    #1;
    tq.push_back(tag); rq.push_back(m_res); pq.push_back(m_psw);
    exec = 1'b0; ctl_we = 1'b0; load_en = 1'b0;
  endtask

  // monitor: pops expected items and compares
  always @(negedge clk) begin
    if (rq.size() > 0) begin
      string t;
      logic [15:0] er, ep;
      t = tq.pop_front(); er = rq.pop_front(); ep = pq.pop_front();
      check(t, "result", result, er);
      check(t, "psw", psw, ep);
      check("R12", "flag pins", {7'h0, of, df, ief, tf, sf, zf, af, pf, cf},
            {7'h0, ep[11], ep[10], ep[9], ep[8], ep[7], ep[6], ep[4], ep[2], ep[0]});
    end
  end

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1", "reset result", result, 16'h0);
    check("R1", "reset psw", psw, 16'hF000);

    // R2 R3 R4 R5 R6 R7 byte adds
    step("R4", 16'h000F, 16'h0001, 0, 3'd0, 0, 1, 0, 3'b000, 0, 16'h0);
    step("R5", 16'h007F, 16'h0001, 0, 3'd0, 0, 1, 0, 3'b000, 0, 16'h0);
    step("R3", 16'h00FF, 16'h0001, 0, 3'd0, 0, 1, 0, 3'b000, 0, 16'h0);
    step("R2", 16'hAB12, 16'h7F34, 1, 3'd0, 0, 1, 0, 3'b000, 0, 16'h0);
    // word adds
    step("R5", 16'h7FFF, 16'h0001, 0, 3'd0, 1, 1, 0, 3'b000, 0, 16'h0);
    step("R3", 16'hFFFF, 16'h0000, 1, 3'd0, 1, 1, 0, 3'b000, 0, 16'h0);
    step("R7", 16'h0200, 16'h0100, 0, 3'd0, 1, 1, 0, 3'b000, 0, 16'h0);
    // subtracts
    step("R4", 16'h0010, 16'h0001, 0, 3'd1, 0, 1, 0, 3'b000, 0, 16'h0);
    step("R3", 16'h0000, 16'h0001, 0, 3'd1, 0, 1, 0, 3'b000, 0, 16'h0);
    step("R5", 16'h8000, 16'h0001, 0, 3'd1, 1, 1, 0, 3'b000, 0, 16'h0);
    step("R2", 16'h1234, 16'h1233, 1, 3'd1, 1, 1, 0, 3'b000, 0, 16'h0);
    step("R6", 16'h0080, 16'h0001, 1, 3'd1, 0, 1, 0, 3'b000, 0, 16'h0);
    // logic ops after a flagging op
    step("R8", 16'hFFFF, 16'h0001, 0, 3'd0, 1, 1, 0, 3'b000, 0, 16'h0);
    step("R8", 16'hF0F3, 16'h0F35, 0, 3'd2, 0, 1, 0, 3'b000, 0, 16'h0);
    step("R8", 16'h8000, 16'h0001, 0, 3'd3, 1, 1, 0, 3'b000, 0, 16'h0);
    step("R8", 16'h5AA5, 16'h5AA5, 0, 3'd4, 1, 1, 0, 3'b000, 0, 16'h0);
    // control flags
    step("R9", 16'h0, 16'h0, 0, 3'd0, 0, 0, 1, 3'b111, 0, 16'h0);
    step("R9", 16'h00FF, 16'h00FF, 1, 3'd0, 0, 1, 0, 3'b000, 0, 16'h0);
    step("R9", 16'h1111, 16'h2222, 0, 3'd1, 1, 1, 1, 3'b010, 0, 16'h0);
    // idle and reserved codes
    step("R10", 16'h1234, 16'h4321, 1, 3'd0, 1, 0, 0, 3'b000, 0, 16'h0);
    step("R10", 16'hFFFF, 16'h0001, 0, 3'd5, 1, 1, 0, 3'b000, 0, 16'h0);
    step("R10", 16'h00FF, 16'h0001, 0, 3'd7, 0, 1, 0, 3'b000, 0, 16'h0);
    // restores
    step("R11", 16'h0, 16'h0, 0, 3'd0, 0, 0, 0, 3'b000, 1, 16'hFFFF);
    step("R11", 16'h00FF, 16'h0001, 0, 3'd0, 0, 1, 1, 3'b000, 1, 16'h0000);
    step("R11", 16'h0, 16'h0, 0, 3'd0, 0, 0, 0, 3'b000, 1, 16'h0A2A);
    step("R12", 16'h0, 16'h0, 0, 3'd0, 1, 1, 0, 3'b000, 0, 16'h0);
    // reset again
    step("R1", 16'h00FF, 16'h0001, 0, 3'd0, 0, 1, 1, 3'b111, 0, 16'h0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1", "re-reset psw", psw, 16'hF000);
    check("R1", "re-reset result", result, 16'h0);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule